// File: doc/BRIEF.md
# Register Request to Half-Duplex Byte Link Master

This block sits between a local register request port and a narrow half-duplex byte channel. A request arrives as a one-cycle read or write strobe with a 20-bit address and 32-bit write data. The block turns it into a short burst of bytes and sends them over the channel. It owns the channel's direction line. Once the request bytes are out, it turns the channel around and collects the reply bytes sent back by a remote slave. It checks the reply for well-formedness, then completes the local request with a one-cycle acknowledge, a 2-bit status and, for reads, the returned data.

The controller is a single state machine with six states:

- `S_IDLE`: direction high, channel quiet.
- `S_LEAD`: direction low, with a settling gap before sending.
- `S_SEND`: request bytes go out, one per cycle.
- `S_COLLECT`: direction high, reply bytes are gathered.
- `S_ABORT`: direction low, used to cancel a reply that never finished.
- `S_DONE`: the local acknowledge.

Its transitions are:

- IDLE to LEAD on a strobe whose address fits the link.
- IDLE to DONE on a strobe with an address that cannot be sent.
- LEAD to SEND when the gap has elapsed.
- SEND to COLLECT after the last request byte.
- COLLECT to DONE on the final reply byte.
- COLLECT to ABORT when the reply timer expires.
- ABORT to DONE when the abort gap has elapsed.
- DONE to IDLE always.

Only one request is handled at a time.

Top module: `ctl_byte_link_master`

## Requirements
- R1: A request is taken only in idle, on `req_wr` or `req_rd` high; if both are high it is a write. Strobes that arrive while a transaction is in progress are dropped: they produce no bytes and no acknowledge.
- R2: Before the first request byte, `link_dir` is low with `link_dout_valid` low for exactly GAP_CYCLES cycles (default 2).
- R3: A write is sent as 6 bytes on consecutive cycles, with `link_dout_valid` high. Byte 0 is {1'b1, addr[14:8]}, byte 1 is addr[7:0], and bytes 2 to 5 are the write data, most significant byte first.
- R4: A read is sent as 2 bytes on consecutive cycles. Byte 0 is {1'b0, addr[14:8]} and byte 1 is addr[7:0].
- R5: In idle, `link_dir` is high. In the cycle after the last request byte, `link_dir` is high again and stays high while the reply is collected.
- R6: A write reply is 1 byte, the status byte. A read reply is 5 bytes: 4 data bytes, most significant first, then the status byte. Only cycles with `link_din_valid` high count, so gaps between reply bytes are allowed.
- R7: A status byte is well formed when bits 7:3 are zero and bit 2 is one. If it is well formed, `resp_status` equals its bits 1:0 and, for reads, `resp_rdata` is the returned data. Otherwise `resp_status` is 2'b11 and `resp_rdata` is zero.
- R8: Suppose the reply is still incomplete after TIMEOUT_CYCLES cycles with `link_dir` high (default 64). Then `link_dir` goes low for GAP_CYCLES cycles, after which the request is acknowledged with status 2'b11 and zero data. The acknowledge falls TIMEOUT_CYCLES+GAP_CYCLES cycles after the first collect cycle.
- R9: A request with any of addr[19:15] set is acknowledged in the next cycle with status 2'b11. Nothing is sent and `link_dir` does not change.
- R10: `resp_ack` is a single-cycle pulse, one for each accepted request. It appears in the cycle after the clock edge that takes the final reply byte, and `resp_rdata` is zero for writes.
- R11: Bytes that arrive on `link_din` while the block is not collecting a reply are ignored, and they do not disturb the next reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_wr | input | 1 | Write request strobe |
| req_rd | input | 1 | Read request strobe |
| req_addr | input | 20 | Request address |
| req_wdata | input | 32 | Write data |
| resp_ack | output | 1 | One-cycle completion pulse |
| resp_status | output | 2 | Completion status, 2'b11 for a link failure |
| resp_rdata | output | 32 | Read data, valid with `resp_ack` |
| link_dout | output | 8 | Byte sent to the slave |
| link_dout_valid | output | 1 | `link_dout` carries a byte this cycle |
| link_dir | output | 1 | Channel direction: low means master sends, high means slave replies |
| link_din | input | 8 | Byte received from the slave |
| link_din_valid | input | 1 | `link_din` carries a byte this cycle |

## Verification
A controller stuck in the wrong state, or a miscounted byte counter, shows on the channel within one byte time. A frame that is too short or too long changes the number of valid bytes the monitor sees. The direction line would then not rise in the cycle right after the last byte, or it would fall too early before sending. Reply counting and status decoding show on the local port in the acknowledge cycle, as a wrong status, wrong data, or an acknowledge one cycle early or late. A timer fault shows as an acknowledge cycle count that misses TIMEOUT_CYCLES+GAP_CYCLES.

// File: rtl/ctl_link_pkg.sv
package ctl_link_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD,
        S_SEND,
        S_COLLECT,
        S_ABORT,
        S_DONE
    } link_state_t;

    // address bits carried in the request header
    localparam int SENT_ADDR_W = 15;
    // reply status byte: marker position and fixed-zero field
    localparam int MARK_POS    = 2;
    // local status reported on any link failure
    localparam logic [1:0] LINK_ERR = 2'b11;

endpackage

// File: rtl/cbm_frame_builder.sv
module cbm_frame_builder #(
    parameter int DATA_W = 32,
    parameter int HDR_ADDR_W = 15
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  load_wr,
    input  logic [HDR_ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0]     load_data,
    input  logic                  advance,
    output logic [7:0]            byte_out,
    output logic                  last_byte
);
    localparam int FRAME_W     = 1 + HDR_ADDR_W + DATA_W;
    localparam int HDR_BYTES   = (1 + HDR_ADDR_W) / 8;
    localparam int FRAME_BYTES = FRAME_W / 8;
    localparam int CNT_W       = $clog2(FRAME_BYTES + 1);

    logic [FRAME_W-1:0] shift_q;
    logic [CNT_W-1:0]   remaining_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q     <= '0;
            remaining_q <= '0;
        end else if (load) begin
            shift_q     <= {load_wr, load_addr, (load_wr ? load_data : {DATA_W{1'b0}})};
            remaining_q <= load_wr ? CNT_W'(FRAME_BYTES) : CNT_W'(HDR_BYTES);
        end else if (advance) begin
            shift_q     <= {shift_q[FRAME_W-9:0], 8'h00};
            remaining_q <= remaining_q - 1'b1;
        end
    end

    assign byte_out  = shift_q[FRAME_W-1 -: 8];
    assign last_byte = (remaining_q == CNT_W'(1));

    // R3, R4: the controller never asks for more bytes than were framed
    a_r3_frame_not_overrun: assert property (@(posedge clk) disable iff (rst)
        advance |-> (remaining_q != '0));

endmodule

// File: rtl/cbm_reply_collector.sv
module cbm_reply_collector #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              accept,
    input  logic [7:0]        byte_in,
    input  logic              expect_wr,
    output logic              final_byte,
    output logic [DATA_W-1:0] data_out,
    output logic [7:0]        status_byte
);
    localparam int REPLY_W  = DATA_W + 8;
    localparam int RD_BYTES = REPLY_W / 8;
    localparam int WR_BYTES = 1;
    localparam int CNT_W    = $clog2(RD_BYTES + 1);

    logic [REPLY_W-1:0] shift_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   need;

    assign need = expect_wr ? CNT_W'(WR_BYTES) : CNT_W'(RD_BYTES);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (accept) begin
            shift_q <= {shift_q[REPLY_W-9:0], byte_in};
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign final_byte  = accept && (cnt_q == need - 1'b1);
    assign data_out    = shift_q[REPLY_W-1:8];
    assign status_byte = shift_q[7:0];

    // R6: a reply byte is only taken while fewer than the expected count arrived
    a_r6_reply_in_bounds: assert property (@(posedge clk) disable iff (rst)
        accept |-> (cnt_q < need));

endmodule

// File: rtl/cbm_reply_timer.sv
module cbm_reply_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == CNT_W'(LIMIT - 1));

    // R8: expiry only after the timer was already running the cycle before
    a_r8_expiry_follows_run: assert property (@(posedge clk) disable iff (rst)
        expired |-> $past(run));

endmodule

// File: rtl/ctl_byte_link_master.sv
module ctl_byte_link_master
    import ctl_link_pkg::*;
#(
    parameter int ADDR_W         = 20,
    parameter int DATA_W         = 32,
    parameter int GAP_CYCLES     = 2,
    parameter int TIMEOUT_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_wr,
    input  logic              req_rd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_ack,
    output logic [1:0]        resp_status,
    output logic [DATA_W-1:0] resp_rdata,
    output logic [7:0]        link_dout,
    output logic              link_dout_valid,
    output logic              link_dir,
    input  logic [7:0]        link_din,
    input  logic              link_din_valid
);
    localparam int STEP_W = $clog2(GAP_CYCLES + 1);

    link_state_t       state_q, state_d;
    logic [STEP_W-1:0] step_q;
    logic              txn_wr_q;
    logic              txn_err_q;

    logic              req_any;
    logic              addr_bad;
    logic              gap_done;
    logic              frame_load;
    logic [7:0]        frame_byte;
    logic              frame_last;
    logic              reply_accept;
    logic              reply_final;
    logic [DATA_W-1:0] reply_data;
    logic [7:0]        reply_status;
    logic              timer_expired;
    logic              status_ok;

    assign req_any = req_wr || req_rd;

    generate
        if (ADDR_W > SENT_ADDR_W) begin : g_hi_addr
            assign addr_bad = |req_addr[ADDR_W-1:SENT_ADDR_W];
        end else begin : g_no_hi_addr
            assign addr_bad = 1'b0;
        end
    endgenerate

    assign gap_done     = (step_q == STEP_W'(GAP_CYCLES - 1));
    assign frame_load   = (state_q == S_IDLE) && req_any && !addr_bad;
    assign reply_accept = (state_q == S_COLLECT) && link_din_valid;

    cbm_frame_builder #(
        .DATA_W     (DATA_W),
        .HDR_ADDR_W (SENT_ADDR_W)
    ) u_frame (
        .clk       (clk),
        .rst       (rst),
        .load      (frame_load),
        .load_wr   (req_wr),
        .load_addr (req_addr[SENT_ADDR_W-1:0]),
        .load_data (req_wdata),
        .advance   (state_q == S_SEND),
        .byte_out  (frame_byte),
        .last_byte (frame_last)
    );

    cbm_reply_collector #(
        .DATA_W (DATA_W)
    ) u_reply (
        .clk         (clk),
        .rst         (rst),
        .clear       (frame_load),
        .accept      (reply_accept),
        .byte_in     (link_din),
        .expect_wr   (txn_wr_q),
        .final_byte  (reply_final),
        .data_out    (reply_data),
        .status_byte (reply_status)
    );

    cbm_reply_timer #(
        .LIMIT (TIMEOUT_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state_q == S_COLLECT),
        .expired (timer_expired)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_any) state_d = addr_bad ? S_DONE : S_LEAD;
            end
            S_LEAD: begin
                if (gap_done) state_d = S_SEND;
            end
            S_SEND: begin
                if (frame_last) state_d = S_COLLECT;
            end
            S_COLLECT: begin
                if (reply_final)        state_d = S_DONE;
                else if (timer_expired) state_d = S_ABORT;
            end
            S_ABORT: begin
                if (gap_done) state_d = S_DONE;
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register and transaction context
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            step_q    <= '0;
            txn_wr_q  <= 1'b0;
            txn_err_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if ((state_q == S_LEAD || state_q == S_ABORT) && state_d == state_q)
                step_q <= step_q + 1'b1;
            else
                step_q <= '0;
            if (state_q == S_IDLE && req_any) begin
                txn_wr_q  <= req_wr;
                txn_err_q <= addr_bad;
            end else if (state_q == S_COLLECT && timer_expired && !reply_final) begin
                txn_err_q <= 1'b1;
            end
        end
    end

    assign status_ok = (reply_status[7:MARK_POS+1] == '0) && reply_status[MARK_POS];

    // outputs
    always_comb begin
        link_dir        = !(state_q == S_LEAD || state_q == S_SEND || state_q == S_ABORT);
        link_dout_valid = (state_q == S_SEND);
        link_dout       = (state_q == S_SEND) ? frame_byte : 8'h00;
        resp_ack        = (state_q == S_DONE);
        resp_status     = 2'b00;
        resp_rdata      = '0;
        if (state_q == S_DONE) begin
            if (!txn_err_q && status_ok) begin
                resp_status = reply_status[1:0];
                if (!txn_wr_q) resp_rdata = reply_data;
            end else begin
                resp_status = LINK_ERR;
            end
        end
    end

    // R2: a request byte is never the first cycle with the direction low
    a_r2_lead_before_send: assert property (@(posedge clk) disable iff (rst)
        $rose(link_dout_valid) |-> $past(!link_dir));

    // R5: the channel is handed back right after the last request byte
    a_r5_turn_after_send: assert property (@(posedge clk) disable iff (rst)
        $fell(link_dout_valid) |-> link_dir);

    // R9: an unsendable address completes at once with the link error code
    a_r9_bad_addr_ack: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && req_any && addr_bad) |=> (resp_ack && resp_status == LINK_ERR));

    // R10: the acknowledge never lasts two cycles
    a_r10_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        resp_ack |=> !resp_ack);

endmodule

// File: tb/ctl_byte_link_master_bench.sv
module ctl_byte_link_master_bench;
    localparam int GAP = 2;
    localparam int TMO = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_wr = 1'b0;
    logic        req_rd = 1'b0;
    logic [19:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_ack;
    logic [1:0]  resp_status;
    logic [31:0] resp_rdata;
    logic [7:0]  link_dout;
    logic        link_dout_valid;
    logic        link_dir;
    logic [7:0]  link_din = '0;
    logic        link_din_valid = 1'b0;

    always #10 clk = ~clk;

    ctl_byte_link_master u_ctl_byte_link_master (
        .clk             (clk),
        .rst             (rst),
        .req_wr          (req_wr),
        .req_rd          (req_rd),
        .req_addr        (req_addr),
        .req_wdata       (req_wdata),
        .resp_ack        (resp_ack),
        .resp_status     (resp_status),
        .resp_rdata      (resp_rdata),
        .link_dout       (link_dout),
        .link_dout_valid (link_dout_valid),
        .link_dir        (link_dir),
        .link_din        (link_din),
        .link_din_valid  (link_din_valid)
    );

    typedef struct {
        logic [1:0]  st;
        logic [31:0] d;
        string       tag;
    } exp_t;

    logic [8:0] exp_frame[$];
    exp_t       exp_resp[$];
    int checks = 0;
    int errors = 0;
    int acks_seen = 0;
    int bytes_seen = 0;
    bit done_flag = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // monitor: frame bytes, direction timing and acknowledge scoreboard
    bit   prev_valid = 0;
    bit   prev_ack = 0;
    int   low_run = 0;
    logic [8:0] fexp;
    exp_t rexp;

    always @(negedge clk) begin
        if (rst) begin
            prev_valid = 0;
            prev_ack = 0;
            low_run = 0;
        end else begin
            if (link_dout_valid) begin
                bytes_seen++;
                if (!prev_valid) check(low_run == GAP, "R2", "lead gap", 64'(low_run), 64'(GAP));
                if (exp_frame.size() == 0) begin
                    check(0, "R1", "unexpected request byte", {56'h0, link_dout}, 64'h0);
                end else begin
                    fexp = exp_frame.pop_front();
                    check(link_dout == fexp[7:0], fexp[8] ? "R3" : "R4", "frame byte",
                          {56'h0, link_dout}, {56'h0, fexp[7:0]});
                end
            end
            if (prev_valid && !link_dout_valid)
                check(link_dir == 1'b1, "R5", "direction after last byte", 64'(link_dir), 64'h1);
            if (link_dir || link_dout_valid) low_run = 0;
            else low_run++;
            if (resp_ack) begin
                acks_seen++;
                check(!prev_ack, "R10", "ack pulse width", 64'(prev_ack), 64'h0);
                if (exp_resp.size() == 0) begin
                    check(0, "R1", "unexpected ack", 64'h1, 64'h0);
                end else begin
                    rexp = exp_resp.pop_front();
                    check(resp_status == rexp.st, rexp.tag, "status",
                          64'(resp_status), 64'(rexp.st));
                    check(resp_rdata == rexp.d, rexp.tag, "rdata",
                          64'(resp_rdata), 64'(rexp.d));
                end
            end
            prev_valid = link_dout_valid;
            prev_ack = resp_ack;
        end
    end

    // driver: one transaction with a scripted slave reply
    task automatic txn(input bit wr, input bit rd, input logic [19:0] a, input logic [31:0] d,
                       input logic [31:0] rdat, input logic [7:0] st_byte, input int short_by,
                       input int gap, input bit poke, input string tag);
        logic [7:0] rb[5];
        int   nfull;
        int   nrep;
        int   cyc;
        bit   last_dir;
        bit   is_wr;
        bit   bad;
        bit   good;
        exp_t e;
        is_wr = wr;
        bad   = |a[19:15];
        good  = (st_byte[7:3] == 5'b0) && st_byte[2];
        if (!bad) begin
            exp_frame.push_back({is_wr, is_wr, a[14:8]});
            exp_frame.push_back({is_wr, a[7:0]});
            if (is_wr) for (int i = 3; i >= 0; i--) exp_frame.push_back({1'b1, d[i*8 +: 8]});
        end
        e.tag = tag;
        if (bad || short_by > 0 || !good) begin
            e.st = 2'b11;
            e.d  = '0;
        end else begin
            e.st = st_byte[1:0];
            e.d  = is_wr ? 32'h0 : rdat;
        end
        exp_resp.push_back(e);
        @(negedge clk);
        req_wr = wr; req_rd = rd; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_wr = 0; req_rd = 0;
        if (bad) begin
            check(resp_ack == 1'b1, "R9", "ack next cycle", 64'(resp_ack), 64'h1);
            check(link_dir == 1'b1, "R9", "direction untouched", 64'(link_dir), 64'h1);
            @(negedge clk);
            return;
        end
        cyc = 0;
        while (!link_dir && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        if (is_wr) begin
            rb[0] = st_byte;
            nfull = 1;
        end else begin
            for (int i = 0; i < 4; i++) rb[i] = rdat[31-8*i -: 8];
            rb[4] = st_byte;
            nfull = 5;
        end
        nrep = nfull - short_by;
        cyc = 1;
        for (int i = 0; i < nrep; i++) begin
            if (i > 0) repeat (gap) begin
                link_din_valid = 0;
                @(negedge clk);
                cyc++;
            end
            link_din = rb[i];
            link_din_valid = 1;
            if (i == 0 && poke) begin
                req_rd = 1;
                req_addr = 20'h00123;
            end
            @(negedge clk);
            cyc++;
            req_rd = 0;
        end
        link_din_valid = 0;
        if (short_by == 0) begin
            check(resp_ack == 1'b1, "R10", "ack after final reply byte", 64'(resp_ack), 64'h1);
        end else begin
            last_dir = link_dir;
            while (!resp_ack && cyc < 1000) begin
                last_dir = link_dir;
                @(negedge clk);
                cyc++;
            end
            check(cyc == TMO + GAP + 1, "R8", "ack cycle after timeout", 64'(cyc), 64'(TMO + GAP + 1));
            check(last_dir == 1'b0, "R8", "direction low before ack", 64'(last_dir), 64'h0);
        end
        @(negedge clk);
    endtask

    int bytes_before;
    int acks_before;

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(link_dir == 1'b1, "R5", "idle direction", 64'(link_dir), 64'h1);
        check(link_dout_valid == 1'b0, "R5", "idle valid", 64'(link_dout_valid), 64'h0);
        check(resp_ack == 1'b0, "R10", "idle ack", 64'(resp_ack), 64'h0);

        // R3 R7: write, well-formed status
        txn(1, 0, 20'h01234, 32'hDEADBEEF, 32'h0, 8'h04, 0, 0, 0, "R7");
        // R4 R6 R7: read, data returned
        txn(0, 1, 20'h07FFF, 32'h0, 32'hCAFEF00D, 8'h05, 0, 0, 0, "R6");
        // R6: read reply with idle gaps between bytes
        txn(0, 1, 20'h00A5C, 32'h0, 32'h01020304, 8'h06, 0, 3, 0, "R6");
        // R7: write reply without marker
        txn(1, 0, 20'h00010, 32'h11223344, 32'h0, 8'h03, 0, 0, 0, "R7");
        // R7: read reply with a nonzero upper status bit
        txn(0, 1, 20'h00020, 32'h0, 32'h55667788, 8'h84, 0, 0, 0, "R7");
        // R9: address outside the sendable range
        bytes_before = bytes_seen;
        txn(1, 0, 20'h80001, 32'h99999999, 32'h0, 8'h04, 0, 0, 0, "R9");
        repeat (4) @(negedge clk);
        check(bytes_seen == bytes_before, "R9", "no bytes sent", 64'(bytes_seen), 64'(bytes_before));
        // R1: both strobes act as a write
        txn(1, 1, 20'h04321, 32'hA5A55A5A, 32'h0, 8'h04, 0, 0, 0, "R1");
        // R8: read with a partial reply times out
        txn(0, 1, 20'h00300, 32'h0, 32'h12345678, 8'h04, 3, 0, 0, "R8");
        // R8: write with no reply at all
        txn(1, 0, 20'h00301, 32'h0BADF00D, 32'h0, 8'h04, 1, 0, 0, "R8");
        // R1: a strobe while busy is dropped
        acks_before = acks_seen;
        txn(1, 0, 20'h00400, 32'h00C0FFEE, 32'h0, 8'h05, 0, 0, 1, "R1");
        bytes_before = bytes_seen;
        repeat (12) @(negedge clk);
        check(bytes_seen == bytes_before, "R1", "no bytes for dropped strobe", 64'(bytes_seen), 64'(bytes_before));
        check(acks_seen == acks_before + 1, "R1", "single ack", 64'(acks_seen), 64'(acks_before + 1));
        // R11: stray bytes while idle are ignored
        for (int i = 0; i < 3; i++) begin
            link_din = 8'h07;
            link_din_valid = 1;
            @(negedge clk);
        end
        link_din_valid = 0;
        txn(0, 1, 20'h00555, 32'h0, 32'hFEEDFACE, 8'h04, 0, 0, 0, "R11");
        repeat (4) @(negedge clk);
        check(exp_resp.size() == 0, "R10", "all requests acknowledged", 64'(exp_resp.size()), 64'h0);
        check(exp_frame.size() == 0, "R3", "all frame bytes sent", 64'(exp_frame.size()), 64'h0);
        done_flag = 1;
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            report();
            $finish;
        end
    end

endmodule